// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Unit

The unit drives four pulse-width-modulated outputs from one free-running counter. A configuration register carries two run controls (run forever, run one period) and a 4-bit scale exponent. The comparators do not see the raw counter. They see a 16-bit window of it, shifted right by the scale exponent. The period is therefore always 2^(16+scale) clock cycles, and it is chosen only by a power of two.

Each channel holds a 16-bit compare value. The channel's match is true while the windowed count is below that value. The output pin is active-low: it is driven low while the match holds. A compare value of zero keeps a channel idle. Even the largest compare value leaves one step per period high, so a 100% duty cycle cannot be produced.

Software reaches the unit through a plain register port with byte addresses. A write takes one cycle. Reads are combinational from the address. New compare and scale values act on the very next cycle, with no shadow copies. Several configuration bits (sticky, zero-compare reset, deglitch, center, gang, interrupt-pending) are kept and read back, but they have no effect.

Top module: `scaled_pwm_unit`

## Requirements
- R1: After reset, every register and the counter read zero, and all four outputs are high (inactive).
- R2: Register map, by byte address. 0x00 is configuration; only bits [3:0], 8, 9, 10, 12, 13, 16, 24 and 28 are stored, and the rest read zero. 0x08 is the counter, 31 bits, and a write loads it. 0x10 is the windowed count, read-only. 0x20+4*i is compare i for i=0..3, with the low 16 bits stored. Other addresses read zero, and writes to them are ignored.
- R3: The counter advances by one each cycle while config bit 12 (run forever) or bit 13 (run one period) is set, and holds otherwise. A counter write wins over counting in the same cycle.
- R4: The counter returns to zero on the cycle after its low 16+scale bits are all ones, so a period is 2^(16+scale) cycles.
- R5: The windowed count equals counter bits [scale+15:scale], where scale is config bits [3:0].
- R6: Output i is low exactly when the windowed count is below compare i. A compare of 0 keeps the output high. A compare of 0xFFFF still gives a high output when the window reads 0xFFFF.
- R7: With bit 13 set and bit 12 clear, bit 13 clears itself on the wrap that ends the period, and counting stops. With bit 12 set, bit 13 stays set and counting goes on.
- R8: A write to a compare value or to the scale affects the outputs from the next cycle. Nothing is held back to a period boundary.
- R9: Config bits 8, 9, 10, 16, 24 and 28 read back as written and change neither counting nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_no | output | 4 | Active-low channel outputs |

## Verification
The hardest case to reach is a period wrap. At scale 0 a wrap takes 65,536 cycles, and at larger scales it takes millions. Reaching the single-pass self-clear, or the wrap boundary after a scale change, by waiting alone is not practical. The stimulus therefore writes the counter to a value a few steps below the wrap point and then lets it run across. A behavioural model follows every cycle, including a long stretch of random register writes that change scale, run bits and counter together.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
    // configuration bit positions the counter logic decodes
    localparam int unsigned BIT_CONT = 12;
    localparam int unsigned BIT_ONCE = 13;
    // byte addresses
    localparam int unsigned OFS_CFG  = 0;
    localparam int unsigned OFS_CNT  = 8;
    localparam int unsigned OFS_VIEW = 16;
    localparam int unsigned OFS_CMP0 = 32;
    // configuration bits that are stored
    localparam logic [31:0] CFG_KEEP = 32'h1101_370F;
endpackage

// File: rtl/spwm_counter.sv
`timescale 1ns/1ps
module spwm_counter #(
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned SCALE_W = 4,
    localparam int unsigned CNT_W  = CMP_W + (1 << SCALE_W) - 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   load_val_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CMP_W-1:0]   view_o,
    output logic               wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic             at_top;
    logic             in_range;

    always_comb begin
        mask     = ~({CNT_W{1'b1}} << (CMP_W + int'(scale_i)));
        at_top   = (st_q.cnt & mask) == mask;
        in_range = (st_q.cnt & mask) == st_q.cnt;
        st_d     = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (run_i) begin
            st_d.cnt = (st_q.cnt + 1'b1) & mask;
        end
        wrap_o = run_i && at_top && !load_i;
        view_o = CMP_W'(st_q.cnt >> scale_i);
        cnt_o  = st_q.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // counter holds when neither run bit is set
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !load_i) |=> $stable(cnt_o));
    // counter steps by one inside the period
    assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !load_i && !at_top && in_range) |=> (cnt_o == $past(cnt_o) + 1'b1));
    // counter returns to zero after the last step of the period
    assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !load_i && at_top) |=> (cnt_o == '0));
endmodule

// File: rtl/spwm_channel.sv
`timescale 1ns/1ps
module spwm_channel #(
    parameter int unsigned CMP_W = 16
) (
    input  logic [CMP_W-1:0] view_i,
    input  logic [CMP_W-1:0] cmp_i,
    output logic             pwm_no
);
    logic match;

    always_comb begin
        match  = view_i < cmp_i;
        pwm_no = !match;
    end
endmodule

// File: rtl/spwm_regs.sv
`timescale 1ns/1ps
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned SCALE_W = 4,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned CNT_W  = CMP_W + (1 << SCALE_W) - 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic                          wrap_i,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [CMP_W-1:0]              view_i,
    output logic [SCALE_W-1:0]            scale_o,
    output logic                          run_o,
    output logic [NUM_CH-1:0][CMP_W-1:0]  cmp_o,
    output logic                          cnt_load_o,
    output logic [CNT_W-1:0]              cnt_val_o,
    output logic [DATA_W-1:0]             rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0]             cfg;
        logic [NUM_CH-1:0][CMP_W-1:0]  cmp;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       cfg_wr;

    always_comb begin
        st_d   = st_q;
        cfg_wr = we_i && (addr_i == ADDR_W'(OFS_CFG));
        if (cfg_wr) begin
            st_d.cfg = wdata_i & DATA_W'(CFG_KEEP);
        end else if (wrap_i && st_q.cfg[BIT_ONCE] && !st_q.cfg[BIT_CONT]) begin
            st_d.cfg[BIT_ONCE] = 1'b0;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (we_i && (addr_i == ADDR_W'(OFS_CMP0 + 4 * i))) begin
                st_d.cmp[i] = wdata_i[CMP_W-1:0];
            end
        end
        cnt_load_o = we_i && (addr_i == ADDR_W'(OFS_CNT));
        cnt_val_o  = wdata_i[CNT_W-1:0];

        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_CFG))  rdata_o = st_q.cfg;
        if (addr_i == ADDR_W'(OFS_CNT))  rdata_o = DATA_W'(cnt_i);
        if (addr_i == ADDR_W'(OFS_VIEW)) rdata_o = DATA_W'(view_i);
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == ADDR_W'(OFS_CMP0 + 4 * i)) rdata_o = DATA_W'(st_q.cmp[i]);
        end

        scale_o = st_q.cfg[SCALE_W-1:0];
        run_o   = st_q.cfg[BIT_CONT] | st_q.cfg[BIT_ONCE];
        cmp_o   = st_q.cmp;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // single pass ends itself at the wrap when run-forever is clear
    assert_once_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && st_q.cfg[BIT_ONCE] && !st_q.cfg[BIT_CONT] && !cfg_wr)
        |=> !run_o);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp_chk
        // compare value acts on the next cycle, no shadow copy
        assert_cmp_direct_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && addr_i == ADDR_W'(OFS_CMP0 + 4 * g))
            |=> (cmp_o[g] == $past(wdata_i[CMP_W-1:0])));
    end
endmodule

// File: rtl/scaled_pwm_unit.sv
`timescale 1ns/1ps
module scaled_pwm_unit #(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned SCALE_W = 4,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NUM_CH-1:0] pwm_no
);
    localparam int unsigned CNT_W = CMP_W + (1 << SCALE_W) - 1;

    logic [SCALE_W-1:0]           scale;
    logic                         run;
    logic [NUM_CH-1:0][CMP_W-1:0] cmp;
    logic                         cnt_load;
    logic [CNT_W-1:0]             cnt_val;
    logic [CNT_W-1:0]             cnt;
    logic [CMP_W-1:0]             view;
    logic                         wrap;

    spwm_regs #(
        .NUM_CH(NUM_CH), .CMP_W(CMP_W), .SCALE_W(SCALE_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wrap_i(wrap), .cnt_i(cnt), .view_i(view),
        .scale_o(scale), .run_o(run), .cmp_o(cmp), .cnt_load_o(cnt_load),
        .cnt_val_o(cnt_val), .rdata_o(rdata_o)
    );

    spwm_counter #(.CMP_W(CMP_W), .SCALE_W(SCALE_W)) counter_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .scale_i(scale),
        .load_i(cnt_load), .load_val_i(cnt_val), .cnt_o(cnt),
        .view_o(view), .wrap_o(wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        spwm_channel #(.CMP_W(CMP_W)) chan_i (
            .view_i(view), .cmp_i(cmp[g]), .pwm_no(pwm_no[g])
        );
        // zero compare keeps the channel idle
        assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp[g] == '0) |-> pwm_no[g]);
    end

    // top window value never drives any output low
    assert_no_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (view == '1) |-> (&pwm_no));
endmodule

// File: tb/scaled_pwm_unit_tb.sv
`timescale 1ns/1ps
module scaled_pwm_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scaled_pwm_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .pwm_no(pwm_n)
    );

    // behavioural reference model
    longint unsigned m_cnt;
    bit [31:0]       m_cfg;
    bit [15:0]       m_cmp [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cfg = 0;
            foreach (m_cmp[k]) m_cmp[k] = 0;
        end else begin
            int unsigned     sc;
            longint unsigned msk, n_cnt;
            bit              run, top, ld;
            bit [31:0]       n_cfg;
            sc    = m_cfg[3:0];
            run   = m_cfg[12] || m_cfg[13];
            msk   = (64'd1 << (16 + sc)) - 1;
            top   = (m_cnt & msk) == msk;
            ld    = we && addr == 6'h08;
            n_cnt = m_cnt;
            if (ld) n_cnt = wdata & 32'h7FFF_FFFF;
            else if (run) n_cnt = (m_cnt + 1) & msk;
            n_cfg = m_cfg;
            if (we && addr == 6'h00) n_cfg = wdata & 32'h1101_370F;
            else if (run && top && !ld && m_cfg[13] && !m_cfg[12]) n_cfg[13] = 1'b0;
            for (int k = 0; k < 4; k++)
                if (we && addr == 6'(32 + 4 * k)) m_cmp[k] = wdata[15:0];
            m_cnt = n_cnt;
            m_cfg = n_cfg;
        end
    end

    function automatic bit [15:0] m_view();
        return 16'((m_cnt >> m_cfg[3:0]) & 64'hFFFF);
    endfunction

    function automatic bit [31:0] m_read(input bit [5:0] a);
        case (a)
            6'h00: return m_cfg;
            6'h08: return 32'(m_cnt);
            6'h10: return 32'(m_view());
            6'h20: return 32'(m_cmp[0]);
            6'h24: return 32'(m_cmp[1]);
            6'h28: return 32'(m_cmp[2]);
            6'h2C: return 32'(m_cmp[3]);
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit [3:0] m_pwm();
        bit [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = !(m_view() < m_cmp[k]);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 outputs vs model", 32'(pwm_n), 32'(m_pwm()));
            chk("R2 readback vs model", rdata, m_read(addr));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pin(input string tag, input logic [3:0] exp);
        #1;
        chk(tag, 32'(pwm_n), 32'(exp));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd("R1 cfg", 6'h00, 32'h0);
        rd("R1 cnt", 6'h08, 32'h0);
        for (int k = 0; k < 4; k++) rd("R1 cmp", 6'(32 + 4 * k), 32'h0);
        pin("R1 outputs idle", 4'hF);

        // R2 and R9: masked config, mode bits stored, run clear
        wr(6'h00, 32'hFFFF_CFFF);
        rd("R2 cfg mask", 6'h00, 32'h1101_070F);
        idle(3);
        rd("R9 no counting from mode bits", 6'h08, 32'h0);
        wr(6'h00, 32'h0);
        wr(6'h04, 32'hDEAD_BEEF);
        rd("R2 hole reads zero", 6'h04, 32'h0);
        wr(6'h30, 32'h1234_5678);
        rd("R2 beyond last compare", 6'h30, 32'h0);
        wr(6'h10, 32'h0000_5555);
        rd("R2 window read-only", 6'h10, 32'h0);
        wr(6'h20, 32'h0000_0003);
        wr(6'h24, 32'h0000_FFFF);
        wr(6'h28, 32'h0000_0000);
        wr(6'h2C, 32'h0001_2345);
        rd("R2 compare low half", 6'h2C, 32'h0000_2345);
        pin("R6 pattern at zero", 4'h4);

        // R3 counting
        wr(6'h00, 32'h0000_1000);
        idle(5);
        rd("R3 counted five", 6'h08, 32'd5);
        pin("R6 above compare0", 4'h5);

        // R4 wrap at scale 0, R6 full compare
        wr(6'h08, 32'h0000_FFFD);
        rd("R3 load wins", 6'h08, 32'h0000_FFFD);
        idle(2);
        rd("R5 top window", 6'h10, 32'h0000_FFFF);
        pin("R6 no full duty", 4'hF);
        idle(1);
        rd("R4 wrap scale0", 6'h08, 32'h0);

        // R5 scaled window, R4 wrap at scale 4
        wr(6'h00, 32'h0000_1004);
        wr(6'h08, 32'h0001_2345);
        rd("R5 window scale4", 6'h10, 32'h0000_1234);
        pin("R6 at 0x1234", 4'h5);
        wr(6'h08, 32'h000F_FFFE);
        idle(1);
        rd("R4 before wrap scale4", 6'h08, 32'h000F_FFFF);
        idle(1);
        rd("R4 wrap scale4", 6'h08, 32'h0);

        // R8 compare acts at once
        wr(6'h28, 32'h0000_8000);
        pin("R8 new compare next cycle", 4'h0);

        // R3 hold when run bits clear
        wr(6'h00, 32'h0000_0004);
        idle(3);
        rd("R3 holds", 6'h08, 32'd2);

        // R7 single pass
        wr(6'h00, 32'h0000_2000);
        wr(6'h08, 32'h0000_FFFE);
        idle(1);
        rd("R7 running", 6'h08, 32'h0000_FFFF);
        idle(1);
        rd("R7 bit clears", 6'h00, 32'h0);
        idle(3);
        rd("R7 stopped", 6'h08, 32'h0);

        // R7 run-forever has priority
        wr(6'h00, 32'h0000_3000);
        wr(6'h08, 32'h0000_FFFF);
        idle(1);
        rd("R7 bit kept", 6'h00, 32'h0000_3000);
        idle(2);
        rd("R7 keeps counting", 6'h08, 32'd2);

        // R9 mode bits with counting
        wr(6'h00, 32'h1101_1700);
        wr(6'h08, 32'd5);
        idle(4);
        rd("R9 counts normally", 6'h08, 32'd9);
        rd("R9 bits read back", 6'h00, 32'h1101_1700);
        pin("R9 outputs unchanged", 4'h1);

        // random register traffic, compared with the model every cycle
        for (int n = 0; n < 1500; n++) begin
            int unsigned sel;
            logic [5:0]  a;
            sel = $urandom_range(0, 8);
            case (sel)
                0: a = 6'h00; 1: a = 6'h08; 2: a = 6'h10;
                3: a = 6'h20; 4: a = 6'h24; 5: a = 6'h28;
                6: a = 6'h2C; 7: a = 6'h04; default: a = 6'h30;
            endcase
            we = ($urandom_range(0, 3) == 0);
            addr = a;
            wdata = $urandom();
            if (a == 6'h08) wdata = {16'h0, wdata[15:0]};
            if (a == 6'h00) wdata[3:2] = 2'b00;
            @(negedge clk); #1;
        end
        we = 1'b0;
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule